// File: doc/BRIEF.md
# Wide-beat SECDED read decoder

The block takes one wide beat made of several extended-Hamming codewords placed side by side and gives back the data lanes they protect. Each codeword holds one data lane. The block fixes any single flipped bit in a codeword and reports any codeword with two flipped bits. The decoded beat, its valid strobe and two status pulses appear together one clock after the beat is accepted. One pulse means a single error was corrected somewhere in the beat. The other means an uncorrectable double error was seen somewhere in the beat.

An enable input turns correction on or off at run time. When it is low, the data bits are copied out of each codeword unchanged and no status pulse is raised. The status pulses are raised only for beats that carry a valid strobe, so corrupt values on an idle bus raise nothing.

Top module: `ecc_rd_decoder`

## Requirements
- R1: A codeword is CODE_W = DATA_W + HAM_R + 1 bits (39 for 32 data bits). Bit 0 makes the whole codeword even parity. Positions 1..CODE_W-1 follow a Hamming layout: check bits sit at power-of-two positions, and data bit j sits at the j-th non-power-of-two position in ascending order. Lane k uses code bits [k*CODE_W +: CODE_W] and data bits [k*DATA_W +: DATA_W]. A clean codeword gives back its data with no status pulse.
- R2: out_valid is in_valid delayed by exactly one clock. out_data, sec and ded belong to the beat accepted on the same edge. Back-to-back beats come out back to back.
- R3: sec and ded are 0 in every cycle that follows a cycle with in_valid low, even when the codeword presented is corrupt.
- R4: With enable high, a single flipped data or check bit in a lane is corrected. The output lane equals the original data, and sec pulses with ded low.
- R5: With enable high, a codeword whose only fault is the overall parity bit (bit 0) raises sec and not ded, and its data is unchanged.
- R6: With enable high, two flipped bits in a lane raise ded, and that lane does not raise sec.
- R7: With enable low, no correction is applied (the data bits are copied out as received) and neither sec nor ded is raised.
- R8: sec is the OR of the lane single-error indications of the beat, and ded is the OR of the lane double-error indications. Both can be high for one beat. Each is a one-cycle pulse per valid beat.
- R9: During reset, and on the first edge after reset is asserted, out_valid, sec and ded are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Correction and flagging enable |
| in_valid | input | 1 | Input beat valid |
| in_code | input | LANES*CODE_W | Concatenated codewords |
| out_valid | output | 1 | Decoded beat valid |
| out_data | output | LANES*DATA_W | Decoded data lanes |
| sec | output | 1 | Single error corrected in the beat |
| ded | output | 1 | Double error detected in the beat |

## Verification
Every result of the block is due one clock after the rising edge that accepts the beat. On that edge out_valid, out_data, sec and ded are all registered together. The driver changes inputs on the falling edge and pushes the expected result into a queue at the same time. The monitor samples 1 ns after each rising edge and pops one entry for each out_valid it sees, so a missing, extra or late beat shows up as a mismatch or a leftover entry. Cycles with in_valid low that carry corrupt codewords are checked for sec and ded both low in the following sample.

// File: rtl/ecc_rd_pkg.sv
package ecc_rd_pkg;

  function automatic bit is_pow2(input int unsigned p);
    return (p != 0) && ((p & (p - 1)) == 0);
  endfunction

  // smallest r with 2**r >= data bits + r + 1
  function automatic int unsigned ham_bits(input int unsigned dw);
    int unsigned r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

endpackage

// File: rtl/ecc_rd_syndrome.sv
module ecc_rd_syndrome #(
  parameter int CODE_W = 39,
  parameter int SYN_W  = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [SYN_W-1:0]  syn,
  output logic              par_bad
);
  always_comb begin
    syn = '0;
    for (int p = 1; p < CODE_W; p++)
      if (code[p]) syn = syn ^ SYN_W'(p);
  end

  assign par_bad = ^code;
endmodule

// File: rtl/ecc_lane_decode.sv
module ecc_lane_decode
  import ecc_rd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HAM_R  = 6,
  parameter int CODE_W = DATA_W + HAM_R + 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic [DATA_W-1:0] data,
  output logic              single_err,
  output logic              double_err
);
  logic [HAM_R-1:0]  syn;
  logic              par_bad;
  logic              syn_nz;
  logic              syn_oor;
  logic [CODE_W-1:0] fixed;

  ecc_rd_syndrome #(.CODE_W(CODE_W), .SYN_W(HAM_R)) u_syn (
    .code    (code),
    .syn     (syn),
    .par_bad (par_bad)
  );

  assign syn_nz  = (syn != '0);
  assign syn_oor = (int'(syn) >= CODE_W);

  assign single_err = enable && par_bad && !syn_oor;
  assign double_err = enable && ((!par_bad && syn_nz) || (par_bad && syn_oor));

  always_comb begin
    fixed = code;
    if (single_err)
      for (int p = 1; p < CODE_W; p++)
        if (int'(syn) == p) fixed[p] = ~code[p];
  end

  always_comb begin
    int j;
    j = 0;
    data = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!is_pow2(p)) begin
        data[j] = fixed[p];
        j++;
      end
    end
  end
endmodule

// File: rtl/ecc_rd_decoder.sv
module ecc_rd_decoder
  import ecc_rd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  localparam int HAM_R  = ham_bits(DATA_W),
  localparam int CODE_W = DATA_W + HAM_R + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    in_valid,
  input  logic [LANES*CODE_W-1:0] in_code,
  output logic                    out_valid,
  output logic [LANES*DATA_W-1:0] out_data,
  output logic                    sec,
  output logic                    ded
);
  logic [LANES*DATA_W-1:0] dec_data;
  logic [LANES-1:0]        lane_sec;
  logic [LANES-1:0]        lane_ded;
  logic                    beat_sec;
  logic                    beat_ded;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ecc_lane_decode #(.DATA_W(DATA_W), .HAM_R(HAM_R), .CODE_W(CODE_W)) u_lane (
      .code       (in_code[k*CODE_W +: CODE_W]),
      .enable     (enable),
      .data       (dec_data[k*DATA_W +: DATA_W]),
      .single_err (lane_sec[k]),
      .double_err (lane_ded[k])
    );
  end

  assign beat_sec = in_valid && (|lane_sec);
  assign beat_ded = in_valid && (|lane_ded);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sec       <= 1'b0;
      ded       <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      sec       <= beat_sec;
      ded       <= beat_ded;
      if (in_valid) out_data <= dec_data;
    end
  end
endmodule

// File: rtl/ecc_rd_checker.sv
module ecc_rd_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             in_valid,
  input logic             out_valid,
  input logic             sec,
  input logic             ded,
  input logic [LANES-1:0] lane_sec,
  input logic [LANES-1:0] lane_ded
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  p_flags_need_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec || ded) |-> out_valid);

  p_lane_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sec & lane_ded) == '0);

  p_quiet_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(enable)) |-> (!sec && !ded));

  p_sec_or_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid)) |-> (sec == $past(|lane_sec) && ded == $past(|lane_ded)));

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !sec && !ded));
endmodule

bind ecc_rd_decoder ecc_rd_checker #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .sec       (sec),
  .ded       (ded),
  .lane_sec  (lane_sec),
  .lane_ded  (lane_ded)
);

// File: tb/tb_ecc_rd_decoder.sv
`timescale 1ns/1ps
module tb_ecc_rd_decoder;
  localparam int L  = 4;
  localparam int DW = 32;
  localparam int CW = 39;

  logic clk = 0, rst_n = 0, enable = 1, in_valid = 0;
  logic [L*CW-1:0] in_code = '0;
  logic out_valid, sec, ded;
  logic [L*DW-1:0] out_data;

  always #2 clk = ~clk;  // 250 MHz

  ecc_rd_decoder #(.LANES(L), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_code(in_code), .out_valid(out_valid), .out_data(out_data),
    .sec(sec), .ded(ded)
  );

  typedef struct {
    logic [L*DW-1:0] data;
    bit              chk_data;
    bit              sec;
    bit              ded;
    string           tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;
  bit idle_chk = 0;

  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0; j = 0;
    for (int p = 1; p < CW; p++)
      if ($countones(p) != 1) begin c[p] = d[j]; j++; end
    for (int k = 0; k < 6; k++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < CW; p++) if (p[k]) x = x ^ c[p];
      c[1 << k] = x;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic logic [DW-1:0] raw(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    d = '0; j = 0;
    for (int p = 1; p < CW; p++)
      if ($countones(p) != 1) begin d[j] = c[p]; j++; end
    return d;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [L*DW-1:0] act, input logic [L*DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [L*CW-1:0] code, input bit en, input exp_t e);
    @(negedge clk);
    in_valid = 1; in_code = code; enable = en;
    q.push_back(e);
  endtask

  task automatic idle(input logic [L*CW-1:0] code);
    @(negedge clk);
    in_valid = 0; in_code = code; enable = 1;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) check(0, "R2 unexpected beat", {127'd0, out_valid}, '0);
        else begin
          exp_t e;
          e = q.pop_front();
          if (e.chk_data) check(out_data == e.data, {e.tag, " data"}, out_data, e.data);
          check(sec == e.sec, {e.tag, " sec"}, {127'd0, sec}, {127'd0, e.sec});
          check(ded == e.ded, {e.tag, " ded"}, {127'd0, ded}, {127'd0, e.ded});
        end
      end else if (idle_chk) begin
        check(!sec && !ded, "R3 flags on idle", {126'd0, sec, ded}, '0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d [L];
    logic [L*CW-1:0] code;
    logic [L*DW-1:0] dat;
    exp_t e;

    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !sec && !ded, "R9 reset state", {125'd0, out_valid, sec, ded}, '0);
    @(negedge clk); rst_n = 1;

    // R1/R2: clean beats back to back, several patterns
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < L; k++) begin
        d[k] = (t == 0) ? 32'h0 : (t == 1) ? 32'hFFFF_FFFF : 32'hA5C3_0F17 ^ (32'h1111_1111 * (t * 4 + k));
        code[k*CW +: CW] = enc(d[k]);
        dat[k*DW +: DW] = d[k];
      end
      e = '{data: dat, chk_data: 1, sec: 0, ded: 0, tag: "R1 R2 clean"};
      send(code, 1, e);
    end

    // R4: single data-bit flip in lane 2, and a check-bit flip in lane 1
    code[2*CW + 5] = ~code[2*CW + 5];
    e = '{data: dat, chk_data: 1, sec: 1, ded: 0, tag: "R4 single data flip"};
    send(code, 1, e);
    code[2*CW + 5] = ~code[2*CW + 5];
    code[1*CW + 16] = ~code[1*CW + 16];
    e = '{data: dat, chk_data: 1, sec: 1, ded: 0, tag: "R4 single check flip"};
    send(code, 1, e);
    code[1*CW + 16] = ~code[1*CW + 16];

    // R5: only the overall parity bit wrong
    code[3*CW] = ~code[3*CW];
    e = '{data: dat, chk_data: 1, sec: 1, ded: 0, tag: "R5 parity bit"};
    send(code, 1, e);
    code[3*CW] = ~code[3*CW];

    // R6: double flip in lane 0
    code[5] = ~code[5]; code[9] = ~code[9];
    e = '{data: dat, chk_data: 0, sec: 0, ded: 1, tag: "R6 double flip"};
    send(code, 1, e);

    // R8: lane 0 double plus lane 3 single
    code[3*CW + 30] = ~code[3*CW + 30];
    e = '{data: dat, chk_data: 0, sec: 1, ded: 1, tag: "R8 mixed lanes"};
    send(code, 1, e);
    code[5] = ~code[5]; code[9] = ~code[9];
    code[3*CW + 30] = ~code[3*CW + 30];

    // R7: enable low, single flip passes through uncorrected
    code[2*CW + 5] = ~code[2*CW + 5];
    for (int k = 0; k < L; k++) dat[k*DW +: DW] = raw(code[k*CW +: CW]);
    e = '{data: dat, chk_data: 1, sec: 0, ded: 0, tag: "R7 disabled"};
    send(code, 0, e);

    // R3: corrupt codewords with valid low
    idle(code);
    idle_chk = 1;
    code[7] = ~code[7]; code[11] = ~code[11];
    idle(code);
    idle(code);
    repeat (3) @(posedge clk);
    idle_chk = 0;

    #2;
    check(q.size() == 0, "R2 missing beats", {96'd0, 32'(q.size())}, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule